// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Idle and Break Generation

This block turns parallel words into frames on one serial line. Each data frame has a low start bit and then the data bits, least significant first. A high stop bit closes the frame. The word is 8 or 9 bits long. When parity is on, the parity bit takes the place of the top data bit; no extra bit is added to the frame. Two other whole-character requests exist. An idle character holds the line high for one character time. A break character holds the line low for one character time and then drives one high bit, so that the far end can find the next start bit.

Bit timing comes from an internal counter. Each bit lasts N system clocks, where N is read from a 16-bit divider input. The user raises a valid or request input while the busy flag is low. The block captures the mode, parity settings, divider and word at that moment. It then sends the complete character and drops busy when the character ends.

Top module: `serial_char_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: With `wide_mode`=0 a data frame is a 0 start bit, then `tx_data[7:0]` LSB first, then a 1 stop bit: 10 bit times.
- R3: With `wide_mode`=1 a data frame is a 0 start bit, then `tx_data[8:0]` LSB first, then a 1 stop bit: 11 bit times.
- R4: With `par_en`=1 the parity bit replaces the last data slot. That slot is bit position 8 of the frame (the data bit 7 slot) in 8-bit mode and bit position 9 (the data bit 8 slot) in 9-bit mode. Parity is computed over the remaining data bits. It is even when `par_odd`=0 and odd when `par_odd`=1.
- R5: An idle character holds `txd` at 1 for 10 bit times (8-bit mode) or 11 bit times (9-bit mode), with `busy` at 1 for that whole time.
- R6: A break character holds `txd` at 0 for 10 bit times (8-bit mode) or 11 bit times (9-bit mode), then at 1 for one more bit time.
- R7: When requests arrive together, break is served first, then idle, then data. Only one character starts, and the requests that lose are dropped.
- R8: While `busy` is 1, `tx_ready` is 0 and the `tx_valid`, `idle_req` and `break_req` inputs are ignored. No character follows the current one.
- R9: Every bit lasts exactly max(`baud_div`,1) clocks. A divider value of 0 gives one clock per bit.
- R10: The mode, parity, divider and data inputs are captured when a character starts. Changing them during the character does not alter that character.
- R11: The clock after the last bit time ends, `busy` returns to 0 and `txd` rests at 1 while nothing is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Clocks per bit; 0 is treated as 1 |
| wide_mode | input | 1 | 0: 8-bit words, 1: 9-bit words |
| par_en | input | 1 | Parity bit replaces the top data slot |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| tx_data | input | 9 | Word to send (bit 8 is used only in 9-bit mode) |
| tx_valid | input | 1 | Request to send `tx_data` |
| tx_ready | output | 1 | High when a data word would be accepted |
| idle_req | input | 1 | Request for one idle character |
| break_req | input | 1 | Request for one break character |
| txd | output | 1 | Serial line |
| busy | output | 1 | A character is being sent |

## Verification
A wrong bit counter or a wrong shift register shows up on `txd` within one bit time. In those cases a data bit, the stop bit or the extra break bit arrives at the wrong position, or `busy` falls early or late. A faulty baud counter stretches or shrinks a bit, and this is visible by the end of the first bit. The bench therefore compares every clock of every bit with a frame built from the requirements. It also moves the inputs and pulses requests in the middle of a character. A design that reads live inputs, or that keeps a request made while busy, then shows a wrong bit or an unexpected extra character.

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             wide_mode,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [8:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             idle_req,
  input  logic             break_req,
  output logic             txd,
  output logic             busy
);

  localparam int FW = 12;
  localparam int LW = $clog2(FW + 1);

  logic [DIV_W-1:0] div_q, cnt;
  logic [FW-1:0]    sh, frame;
  logic [LW-1:0]    left, nbits;
  logic             start, tick, par;

  assign tick     = busy && (cnt == div_q - DIV_W'(1));
  assign start    = !busy && (break_req || idle_req || tx_valid);
  assign tx_ready = !busy && !break_req && !idle_req;
  assign par      = (wide_mode ? ^tx_data[7:0] : ^tx_data[6:0]) ^ par_odd;

  always_comb begin
    frame = '1;
    nbits = wide_mode ? LW'(11) : LW'(10);
    if (break_req) begin
      frame = '0;
      frame[nbits] = 1'b1;
      nbits = nbits + LW'(1);
    end else if (!idle_req) begin
      frame[0] = 1'b0;
      if (wide_mode) begin
        frame[9:1] = tx_data;
        if (par_en) frame[9] = par;
      end else begin
        frame[8:1] = tx_data[7:0];
        if (par_en) frame[8] = par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      sh    <= '0;
      left  <= '0;
      cnt   <= '0;
      div_q <= DIV_W'(1);
    end else if (start) begin
      busy  <= 1'b1;
      txd   <= frame[0];
      sh    <= frame >> 1;
      left  <= nbits - LW'(1);
      cnt   <= '0;
      div_q <= (baud_div == '0) ? DIV_W'(1) : baud_div;
    end else if (tick) begin
      cnt <= '0;
      if (left == '0) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd  <= sh[0];
        sh   <= sh >> 1;
        left <= left - LW'(1);
      end
    end else if (busy) begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  AST_LINE_RESTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R11
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < div_q)); // R9
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd)); // R2
  AST_BREAK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && break_req) |=> (busy && !txd)); // R6
  AST_IDLE_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle_req && !break_req) |=> (busy && txd)); // R5
  AST_DATA_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle_req && !break_req) |=> (busy && !txd)); // R2

endmodule

// File: tb/sim_serial_char_tx.sv
module sim_serial_char_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic wide_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0, idle_req = 1'b0, break_req = 1'b0;
  logic tx_ready, txd, busy;
  int n_run = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  serial_char_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .wide_mode(wide_mode),
    .par_en(par_en), .par_odd(par_odd), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .idle_req(idle_req), .break_req(break_req),
    .txd(txd), .busy(busy));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // kind: 0 data, 1 idle, 2 break, 3 all three at once, 4 idle+data
  function automatic void mk(input int kind, input bit wide, input bit pe,
                             input bit po, input logic [8:0] d,
                             output logic [11:0] f, output int n);
    bit p;
    f = '1;
    n = wide ? 11 : 10;
    p = (wide ? ^d[7:0] : ^d[6:0]) ^ po;
    if (kind == 2 || kind == 3) begin
      f = '0; f[n] = 1'b1; n = n + 1;
    end else if (kind == 0) begin
      f[0] = 1'b0;
      if (wide) begin f[9:1] = d; if (pe) f[9] = p; end
      else begin f[8:1] = d[7:0]; if (pe) f[8] = p; end
    end
  endfunction

  task automatic run_char(input int kind, input bit wide, input bit pe,
                          input bit po, input logic [8:0] d,
                          input logic [15:0] div, input bit disturb,
                          input string tag);
    logic [11:0] f;
    int n, eff, bad_act;
    bit bad, pend;
    mk(kind, wide, pe, po, d, f, n);
    eff = (div == 0) ? 1 : int'(div);
    wide_mode = wide; par_en = pe; par_odd = po; tx_data = d; baud_div = div;
    tx_valid  = (kind == 0 || kind == 3 || kind == 4);
    idle_req  = (kind == 1 || kind == 3 || kind == 4);
    break_req = (kind == 2 || kind == 3);
    @(negedge clk);
    tx_valid = 1'b0; idle_req = 1'b0; break_req = 1'b0;
    pend = 1'b0;
    for (int k = 0; k < n; k++) begin
      bad = 1'b0; bad_act = 0;
      for (int j = 0; j < eff; j++) begin
        if (!bad && (txd !== f[k] || busy !== 1'b1 || tx_ready !== 1'b0)) begin
          bad = 1'b1; bad_act = {txd, busy, tx_ready};
        end
        if (pend) begin
          tx_valid = 1'b0; idle_req = 1'b0; break_req = 1'b0; pend = 1'b0;
        end
        if (disturb && k == 2 && j == 0) begin
          wide_mode = ~wide; par_en = ~pe; par_odd = ~po; tx_data = ~d;
          baud_div = div + 16'd3;
          tx_valid = 1'b1; idle_req = 1'b1; break_req = 1'b1; pend = 1'b1;
        end
        if (disturb && k == 3 && j == 0) begin
          wide_mode = wide; par_en = pe; par_odd = po; tx_data = d; baud_div = div;
        end
        @(negedge clk);
      end
      check(!bad, tag, $sformatf("bit %0d {txd,busy,ready}", k), bad_act,
            {f[k], 2'b10});
    end
    tx_valid = 1'b0; idle_req = 1'b0; break_req = 1'b0;
    check(busy === 1'b0 && txd === 1'b1, "R11", "end {txd,busy}",
          {txd, busy}, 2);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && txd === 1'b1 && tx_ready === 1'b1, "R11 R8",
          "rest {txd,busy,ready}", {txd, busy, tx_ready}, 5);
  endtask

  task automatic test_reset;
    check(txd === 1'b1 && busy === 1'b0 && tx_ready === 1'b1, "R1",
          "reset {txd,busy,ready}", {txd, busy, tx_ready}, 5);
  endtask

  task automatic test_frames8;
    run_char(0, 0, 0, 0, 9'h0A5, 16'd3, 0, "R2");
    run_char(0, 0, 0, 0, 9'h13C, 16'd1, 0, "R2");
  endtask

  task automatic test_frames9;
    run_char(0, 1, 0, 0, 9'h1A5, 16'd2, 0, "R3");
    run_char(0, 1, 0, 0, 9'h100, 16'd1, 0, "R3");
  endtask

  task automatic test_parity;
    run_char(0, 0, 1, 0, 9'h053, 16'd2, 0, "R4");
    run_char(0, 0, 1, 1, 9'h053, 16'd2, 0, "R4");
    run_char(0, 1, 1, 0, 9'h0F1, 16'd1, 0, "R4");
    run_char(0, 1, 1, 1, 9'h1F1, 16'd1, 0, "R4");
  endtask

  task automatic test_idle;
    run_char(1, 0, 0, 0, 9'h000, 16'd2, 0, "R5");
    run_char(1, 1, 0, 0, 9'h000, 16'd1, 0, "R5");
  endtask

  task automatic test_break;
    run_char(2, 0, 0, 0, 9'h1FF, 16'd2, 0, "R6");
    run_char(2, 1, 0, 0, 9'h1FF, 16'd3, 0, "R6");
  endtask

  task automatic test_priority;
    run_char(3, 0, 0, 0, 9'h055, 16'd1, 0, "R7");
    run_char(4, 1, 0, 0, 9'h055, 16'd2, 0, "R7");
  endtask

  task automatic test_divider;
    run_char(0, 0, 0, 0, 9'h0C3, 16'd0, 0, "R9");
    run_char(0, 0, 1, 1, 9'h01E, 16'd5, 0, "R9");
  endtask

  task automatic test_capture;
    run_char(0, 0, 1, 0, 9'h0B6, 16'd4, 1, "R10 R8");
    run_char(0, 1, 0, 0, 9'h14D, 16'd2, 1, "R10 R8");
    run_char(2, 0, 0, 0, 9'h000, 16'd3, 1, "R10 R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_frames8();
    test_frames9();
    test_parity();
    test_idle();
    test_break();
    test_priority();
    test_divider();
    test_capture();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule